// File: doc/BRIEF.md
# PWM Fault Shutdown Controller

This block sits between a three-phase PWM timing unit and the six gate-drive outputs. It combines three shutdown sources: an active-low external trip pin, an active-high analog fault flag, and a software shutdown write strobe. The analog flag is raised when a sensed input leaves its threshold window or is left floating. When any source is active, the block forces all six outputs to their off level and holds the timing unit in reset.

The two hardware sources gate the outputs through a purely combinational path, so they take effect with no clock edge and also while the clock is stopped. Status reporting is synchronous. Each hardware source passes through a two-flop synchronizer before it reaches a sticky fault flag, a one-cycle interrupt strobe and a readable copy of the trip-pin level.

Once the fault flag is set, the outputs stay off until every source is inactive and software writes a clear. After an accepted clear, the timing unit is released. The outputs are re-enabled only at the next period boundary that the timing unit reports, so no partial pulse reaches the gates.

Top module: `pwm_trip_ctrl`

## Requirements
- R1: While `tripPinN` is 0, `pwmOut` is all zeros (the off level) and `timerRst` is 1, with no clock edge needed and with the clock stopped.
- R2: While `anaFault` is 1, `pwmOut` is all zeros and `timerRst` is 1, with no clock edge needed and with the clock stopped.
- R3: A one-cycle pulse on `swShutWr` makes `pwmOut` all zeros, `faultLatched` 1 and `timerRst` 1 after the rising edge that samples it.
- R4: `tripPinLevel` follows the trip pin level (1 = pin high, not tripped) with a latency of two rising edges through a two-flop synchronizer.
- R5: `shutIrq` is high for exactly one cycle in the cycle where `faultLatched` changes from 0 to 1. A further shutdown event while the flag is already set raises no pulse.
- R6: `faultLatched` is sticky. Releasing a hardware source leaves the flag at 1 and `pwmOut` at all zeros.
- R7: A pulse on `swClearWr` is ignored while any synchronized hardware source is active or `swShutWr` is high in the same cycle; `faultLatched` stays 1.
- R8: After an accepted clear, `faultLatched` is 0 and `timerRst` is 0, but `pwmOut` stays all zeros until the rising edge that samples `periodStart` high. From that edge on, `pwmOut` equals `pwmIn`.
- R9: After reset: `faultLatched` is 0, `shutIrq` is 0, `timerRst` is 0, `tripPinLevel` is 1, and `pwmOut` is all zeros until the first `periodStart`.
- R10: A hardware source that asserts between two edges sets `faultLatched` on the third rising edge after it asserts, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Asynchronous active-low reset |
| tripPinN | input | 1 | External trip pin, active low, asynchronous |
| anaFault | input | 1 | Analog threshold/float fault, active high, asynchronous |
| swShutWr | input | 1 | Software shutdown write strobe |
| swClearWr | input | 1 | Software fault clear write strobe |
| periodStart | input | 1 | Period-boundary pulse from the timing unit |
| pwmIn | input | 6 | Raw PWM signals from the timing unit |
| pwmOut | output | 6 | Gated PWM signals to the gate drivers |
| timerRst | output | 1 | Holds the timing unit in reset |
| tripPinLevel | output | 1 | Synchronized trip pin level |
| faultLatched | output | 1 | Sticky shutdown status flag |
| shutIrq | output | 1 | One-cycle shutdown interrupt strobe |

## Verification
The bench stops the clock before it asserts each hardware source. A design that routed the trip through registers would leave the outputs switching, and that failure shows only in this case. It counts edges after a hardware fault, which catches a synchronizer with too few or too many stages through the cycle in which the flag rises. It writes a clear while a source is still held, and writes a second shutdown while the flag is already set; a design that dropped the flag early or raised a second interrupt fails there. It checks that the outputs stay off between an accepted clear and the period boundary, which catches a restart that would emit a truncated pulse.

// File: rtl/pwm_trip_pkg.sv
package pwm_trip_pkg;

  localparam int SRC_TRIP   = 0;
  localparam int SRC_ANA    = 1;
  localparam int NUM_HW_SRC = 2;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_SHUT = 2'd1,
    ST_ARM  = 2'd2
  } tripState_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic setFault;
    logic clrFault;
    logic raiseIrq;
    logic gateOff;
    logic holdTimer;
  } tripStrobe_t;

endpackage

// File: rtl/pwm_trip_sync.sv
module pwm_trip_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);

  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) chain[0] <= '0;
    else       chain[0] <= asyncIn;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain[s] <= '0;
      else       chain[s] <= chain[s-1];
    end
  end

  assign syncOut = chain[STAGES-1];

endmodule

// File: rtl/pwm_trip_fsm.sv
module pwm_trip_fsm
  import pwm_trip_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_HW_SRC-1:0] srcSync,
  input  logic                  swShutWr,
  input  logic                  swClearWr,
  input  logic                  periodStart,
  output tripStrobe_t           strobe
);

  tripState_e state, stateNext;
  logic srcAny;

  assign srcAny = (|srcSync) | swShutWr;

  always_comb begin
    stateNext       = state;
    strobe.setFault = 1'b0;
    strobe.clrFault = 1'b0;
    strobe.raiseIrq = 1'b0;
    unique case (state)
      ST_RUN: begin
        if (srcAny) begin
          stateNext       = ST_SHUT;
          strobe.setFault = 1'b1;
          strobe.raiseIrq = 1'b1;
        end
      end
      ST_SHUT: begin
        if (swClearWr && !srcAny) begin
          stateNext       = ST_ARM;
          strobe.clrFault = 1'b1;
        end
      end
      ST_ARM: begin
        if (srcAny) begin
          stateNext       = ST_SHUT;
          strobe.setFault = 1'b1;
          strobe.raiseIrq = 1'b1;
        end else if (periodStart) begin
          stateNext = ST_RUN;
        end
      end
      default: stateNext = ST_SHUT;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_ARM;
    else       state <= stateNext;
  end

  assign strobe.gateOff   = (state != ST_RUN);
  assign strobe.holdTimer = (state == ST_SHUT);

endmodule

// File: rtl/pwm_trip_datapath.sv
module pwm_trip_datapath
  import pwm_trip_pkg::*;
#(
  parameter int                 NUM_OUT   = 6,
  parameter logic [NUM_OUT-1:0] OFF_VALUE = '0
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tripPinN,
  input  logic               anaFault,
  input  logic [NUM_OUT-1:0] pwmIn,
  input  tripStrobe_t        strobe,
  output logic [NUM_OUT-1:0] pwmOut,
  output logic               timerRst,
  output logic               faultLatched,
  output logic               shutIrq
);

  logic hwOff;

  // Clockless hardware kill path
  assign hwOff = !tripPinN || anaFault;

  for (genvar i = 0; i < NUM_OUT; i++) begin : g_gate
    assign pwmOut[i] = (hwOff || strobe.gateOff) ? OFF_VALUE[i] : pwmIn[i];
  end

  assign timerRst = hwOff || strobe.holdTimer;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      faultLatched <= 1'b0;
      shutIrq      <= 1'b0;
    end else begin
      shutIrq <= strobe.raiseIrq;
      if (strobe.setFault)      faultLatched <= 1'b1;
      else if (strobe.clrFault) faultLatched <= 1'b0;
    end
  end

endmodule

// File: rtl/pwm_trip_ctrl.sv
module pwm_trip_ctrl
  import pwm_trip_pkg::*;
#(
  parameter int NUM_OUT     = 6,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               tripPinN,
  input  logic               anaFault,
  input  logic               swShutWr,
  input  logic               swClearWr,
  input  logic               periodStart,
  input  logic [NUM_OUT-1:0] pwmIn,
  output logic [NUM_OUT-1:0] pwmOut,
  output logic               timerRst,
  output logic               tripPinLevel,
  output logic               faultLatched,
  output logic               shutIrq
);

  logic [NUM_HW_SRC-1:0] srcRaw, srcSync;
  tripStrobe_t           strobe;

  assign srcRaw[SRC_TRIP] = !tripPinN;
  assign srcRaw[SRC_ANA]  = anaFault;

  pwm_trip_sync #(.WIDTH(NUM_HW_SRC), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rstN(rstN), .asyncIn(srcRaw), .syncOut(srcSync)
  );

  assign tripPinLevel = !srcSync[SRC_TRIP];

  pwm_trip_fsm fsm_i (
    .clk(clk), .rstN(rstN), .srcSync(srcSync), .swShutWr(swShutWr),
    .swClearWr(swClearWr), .periodStart(periodStart), .strobe(strobe)
  );

  pwm_trip_datapath #(.NUM_OUT(NUM_OUT)) dp_i (
    .clk(clk), .rstN(rstN), .tripPinN(tripPinN), .anaFault(anaFault),
    .pwmIn(pwmIn), .strobe(strobe), .pwmOut(pwmOut), .timerRst(timerRst),
    .faultLatched(faultLatched), .shutIrq(shutIrq)
  );

endmodule

// File: rtl/pwm_trip_ctrl_chk.sv
module pwm_trip_ctrl_chk #(
  parameter int NUM_OUT = 6
) (
  input logic               clk,
  input logic               rstN,
  input logic               tripPinN,
  input logic               anaFault,
  input logic               swShutWr,
  input logic [NUM_OUT-1:0] pwmOut,
  input logic               timerRst,
  input logic               faultLatched,
  input logic               shutIrq,
  input logic               swClearWr
);

  p_trip_off_r1: assert property (@(posedge clk) disable iff (!rstN)
    !tripPinN |-> (pwmOut == '0) && timerRst);

  p_ana_off_r2: assert property (@(posedge clk) disable iff (!rstN)
    anaFault |-> (pwmOut == '0) && timerRst);

  p_sw_shut_r3: assert property (@(posedge clk) disable iff (!rstN)
    swShutWr |=> faultLatched && (pwmOut == '0));

  p_irq_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    shutIrq |=> !shutIrq);

  p_irq_on_set_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(faultLatched) |-> shutIrq);

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched && !swClearWr |=> faultLatched);

  p_latched_off_r6: assert property (@(posedge clk) disable iff (!rstN)
    faultLatched |-> (pwmOut == '0) && timerRst);

endmodule

bind pwm_trip_ctrl pwm_trip_ctrl_chk #(.NUM_OUT(NUM_OUT)) chk_i (
  .clk(clk), .rstN(rstN), .tripPinN(tripPinN), .anaFault(anaFault),
  .swShutWr(swShutWr), .pwmOut(pwmOut), .timerRst(timerRst),
  .faultLatched(faultLatched), .shutIrq(shutIrq), .swClearWr(swClearWr)
);

// File: tb/pwm_trip_ctrl_tb_top.sv
module pwm_trip_ctrl_tb_top;

  localparam logic [5:0] PAT = 6'b101101;

  logic clk = 1'b0;
  logic clkEn = 1'b1;
  logic rstN = 1'b0;
  logic tripPinN = 1'b1;
  logic anaFault = 1'b0;
  logic swShutWr = 1'b0;
  logic swClearWr = 1'b0;
  logic periodStart = 1'b0;
  logic [5:0] pwmIn = PAT;
  logic [5:0] pwmOut;
  logic timerRst, tripPinLevel, faultLatched, shutIrq;

  int nChecks = 0;
  int nFails = 0;

  always #2 if (clkEn) clk = ~clk;

  pwm_trip_ctrl dut_i (
    .clk(clk), .rstN(rstN), .tripPinN(tripPinN), .anaFault(anaFault),
    .swShutWr(swShutWr), .swClearWr(swClearWr), .periodStart(periodStart),
    .pwmIn(pwmIn), .pwmOut(pwmOut), .timerRst(timerRst),
    .tripPinLevel(tripPinLevel), .faultLatched(faultLatched), .shutIrq(shutIrq)
  );

  task automatic check(input string req, input int actual, input int expected);
    nChecks++;
    if (actual != expected) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
    end
  endtask

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic restart();
    swClearWr = 1'b1; step(); swClearWr = 1'b0;
    periodStart = 1'b1; step(); periodStart = 1'b0;
  endtask

  task automatic t_reset();
    rstN = 1'b0;
    step(); step();
    rstN = 1'b1;
    step();
    check("R9 faultLatched", faultLatched, 0);
    check("R9 shutIrq", shutIrq, 0);
    check("R9 timerRst", timerRst, 0);
    check("R9 tripPinLevel", tripPinLevel, 1);
    check("R9 pwmOut gated", pwmOut, 0);
    periodStart = 1'b1; step(); periodStart = 1'b0;
    check("R8 first boundary pwmOut", pwmOut, PAT);
  endtask

  task automatic t_sw_shutdown();
    swShutWr = 1'b1; step(); swShutWr = 1'b0;
    check("R3 pwmOut off", pwmOut, 0);
    check("R3 faultLatched", faultLatched, 1);
    check("R3 timerRst", timerRst, 1);
    check("R5 irq pulse", shutIrq, 1);
    step();
    check("R5 irq one cycle", shutIrq, 0);
    swShutWr = 1'b1; step(); swShutWr = 1'b0;
    check("R5 no irq while latched", shutIrq, 0);
    swShutWr = 1'b1; swClearWr = 1'b1; step();
    swShutWr = 1'b0; swClearWr = 1'b0;
    check("R7 clear with sw write", faultLatched, 1);
    swClearWr = 1'b1; step(); swClearWr = 1'b0;
    check("R8 cleared flag", faultLatched, 0);
    check("R8 timer released", timerRst, 0);
    check("R8 still gated", pwmOut, 0);
    step(); step();
    check("R8 gated until boundary", pwmOut, 0);
    pwmIn = 6'b010011;
    periodStart = 1'b1; step(); periodStart = 1'b0;
    check("R8 restart", pwmOut, 6'b010011);
    pwmIn = PAT;
  endtask

  task automatic t_trip_pin();
    clkEn = 1'b0;
    #3;
    tripPinN = 1'b0;
    #1;
    check("R1 off without clock", pwmOut, 0);
    check("R1 timerRst without clock", timerRst, 1);
    clkEn = 1'b1;
    step(); step();
    check("R10 not yet latched", faultLatched, 0);
    check("R4 pin level low", tripPinLevel, 0);
    step();
    check("R10 latched third edge", faultLatched, 1);
    check("R5 irq on trip", shutIrq, 1);
    swClearWr = 1'b1; step(); swClearWr = 1'b0;
    check("R7 clear ignored", faultLatched, 1);
    tripPinN = 1'b1;
    step();
    check("R4 level lag", tripPinLevel, 0);
    step();
    check("R4 level high", tripPinLevel, 1);
    step();
    check("R6 sticky flag", faultLatched, 1);
    check("R6 outputs off", pwmOut, 0);
    restart();
    check("R8 restart after trip", pwmOut, PAT);
  endtask

  task automatic t_analog();
    clkEn = 1'b0;
    #3;
    anaFault = 1'b1;
    #1;
    check("R2 off without clock", pwmOut, 0);
    check("R2 timerRst without clock", timerRst, 1);
    clkEn = 1'b1;
    step(); step(); step();
    check("R10 analog latched", faultLatched, 1);
    anaFault = 1'b0;
    step(); step(); step();
    check("R6 analog sticky", faultLatched, 1);
    check("R6 analog outputs off", pwmOut, 0);
    check("R4 pin level unaffected", tripPinLevel, 1);
    restart();
    check("R8 restart after analog", pwmOut, PAT);
  endtask

  logic finished = 1'b0;

  initial begin
    t_reset();
    t_sw_shutdown();
    t_trip_pin();
    t_analog();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    #400000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule